// File: doc/BRIEF.md
# Serial Receiver with Multiprocessor Address Filtering

This block turns an asynchronous serial line into characters. It samples the line with a baud tick at sixteen times the bit rate. A start bit is accepted only if it is still low at its middle, and every later bit is taken once, at its centre. The receiver handles 7, 8 or 9 data bits, sent least significant bit first. In the 7-bit and 8-bit formats an optional parity bit may follow the data. One or two stop bits close the frame. A finished character moves from the shift register into a single-entry receive buffer and sets a buffer-full flag. Reading the buffer clears that flag.

For multi-drop networks the block has an attention state, which it honours only in the nine-bit format. Software raises attention with a strobe. While attention is raised, every character whose ninth bit is 0 (a data character) is dropped. The first character whose ninth bit is 1 (an address character) is buffered and lowers attention on its own, so that every later character is received. Software then checks the address. To ignore the rest of the traffic it raises attention again.

A loopback control takes the receiver input from the local transmit stream instead of the external line. It also forces the nine-bit format with no parity. The line input passes through a two-stage synchronizer before it reaches the sampler.

Top module: `mp_rx`

## Requirements
- R1: A completed character is copied into the buffer and buf_full is set. rx_data holds the data bits, first received bit in bit 0. In the 7-bit format rx_data[7] reads 0.
- R2: A one-cycle rd_stb clears buf_full and err_overrun. If a character completes in the same cycle as the read, it is loaded normally.
- R3: fmt_len selects 7 data bits (0), 8 data bits (1) or 9 data bits (2 or 3). In the nine-bit format the ninth received bit appears on rx_bit9 and par_en is ignored. In every other format rx_bit9 reads 0.
- R4: With par_en set in the 7-bit or 8-bit format, one parity bit follows the data. par_odd=0 selects even parity over data plus parity, and par_odd=1 selects odd parity. err_parity is set with a buffered character whose parity does not match.
- R5: err_frame is set with a buffered character whose first stop bit was sampled low. When two_stop is set, the receiver waits through the second stop bit but does not check its value.
- R6: If a character completes while buf_full is set and no read occurs in that cycle, err_overrun is set, and rx_data and rx_bit9 keep the older character.
- R7: In the nine-bit format, atn_set raises atn. While atn is high, a character with ninth bit 0 is discarded: it changes neither the buffer, nor any flag, nor atn.
- R8: While atn is high, a character with ninth bit 1 is buffered like any other character and atn falls. Every later character is then accepted until atn is raised again.
- R9: Outside the nine-bit format, atn_set has no effect and atn is held at 0.
- R10: With loop_en set, the receiver uses loop_tx, ignores rx_line, and applies the nine-bit no-parity format whatever fmt_len and par_en say.
- R11: irq is high exactly while irq_en and buf_full are both high.
- R12: A low pulse shorter than half a bit period does not start a character.
- R13: After a synchronous reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | External serial input, idle high |
| loop_tx | input | 1 | Local transmit stream used in loopback |
| loop_en | input | 1 | Selects loop_tx as the receive input |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| fmt_len | input | 2 | Data bit count: 0 for 7, 1 for 8, 2 or 3 for 9 |
| par_en | input | 1 | Parity bit present (7-bit and 8-bit formats only) |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | Two stop bits per frame |
| irq_en | input | 1 | Enables the interrupt output |
| atn_set | input | 1 | Strobe that raises attention |
| rd_stb | input | 1 | Strobe that reads the receive buffer |
| rx_data | output | 8 | Buffered data byte |
| rx_bit9 | output | 1 | Buffered ninth bit |
| buf_full | output | 1 | Receive buffer holds an unread character |
| irq | output | 1 | Interrupt request |
| atn | output | 1 | Attention state |
| err_frame | output | 1 | Buffered character had a low first stop bit |
| err_parity | output | 1 | Buffered character had a parity mismatch |
| err_overrun | output | 1 | A character was lost while the buffer was full |

## Verification
The hardest sequence to reach is the attention handshake. It needs a nine-bit format, a raised attention state, data characters that must leave no trace, and then an address character that both fills the buffer and lowers attention. The stimulus follows exactly that order: first a strobe, then a frame with a zero ninth bit, whose effect is checked before the address frame is sent, and then a further data frame that must now be accepted. Loopback is reached by setting a conflicting format and holding the external line low, so that only the forced nine-bit path can give the expected byte. A per-cycle behavioural model also covers timing coincidences that the directed frames do not line up, such as a read landing in the same cycle as a completion.

// File: rtl/mp_rx_pkg.sv
package mp_rx_pkg;

    localparam int DATA_W   = 8;
    localparam int MAX_BITS = 9;
    localparam int IDX_W    = $clog2(MAX_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              b9;
        logic              ferr;
        logic              perr;
    } rx_frame_t;

    // index of the final data bit for a format code
    function automatic logic [IDX_W-1:0] last_bit(input logic [1:0] fmt);
        case (fmt)
            2'd0:    return IDX_W'(6);
            2'd1:    return IDX_W'(7);
            default: return IDX_W'(8);
        endcase
    endfunction

    function automatic logic is_nine(input logic [1:0] fmt);
        return fmt[1];
    endfunction

    // 1 when data plus parity bit do not give the requested sense
    function automatic logic par_bad(input logic [DATA_W-1:0] d,
                                     input logic p, input logic odd);
        return ((^d) ^ p) != odd;
    endfunction

endpackage

// File: rtl/mp_rx_sync.sv
module mp_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/mp_rx_deser.sv
module mp_rx_deser
    import mp_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       sin,
    input  logic [1:0] fmt,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    output logic       done,
    output rx_frame_t  frm
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] HALF = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] FULL = CW'(OSR - 1);

    rx_state_e            st;
    logic [CW-1:0]        cnt;
    logic [IDX_W-1:0]     idx;
    logic [MAX_BITS-1:0]  sh;
    logic                 stop2;
    logic                 pbit;
    logic                 fe1;
    logic [IDX_W-1:0]     lastb;

    assign lastb = last_bit(fmt);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
            stop2 <= 1'b0;
            pbit  <= 1'b0;
            fe1   <= 1'b0;
            done  <= 1'b0;
            frm   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (st)
                    ST_IDLE: begin
                        if (!sin) begin
                            st  <= ST_START;
                            cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == HALF) begin
                            cnt <= '0;
                            if (!sin) begin
                                st  <= ST_DATA;
                                idx <= '0;
                                sh  <= '0;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == FULL) begin
                            cnt     <= '0;
                            sh[idx] <= sin;
                            idx     <= idx + 1'b1;
                            stop2   <= 1'b0;
                            if (idx == lastb)
                                st <= par_en ? ST_PAR : ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == FULL) begin
                            cnt  <= '0;
                            pbit <= sin;
                            st   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == FULL) begin
                            cnt <= '0;
                            if (!stop2) fe1 <= !sin;
                            if (!stop2 && two_stop) begin
                                stop2 <= 1'b1;
                            end else begin
                                st        <= ST_IDLE;
                                done      <= 1'b1;
                                frm.data  <= sh[DATA_W-1:0];
                                frm.b9    <= is_nine(fmt) & sh[MAX_BITS-1];
                                frm.ferr  <= stop2 ? fe1 : !sin;
                                frm.perr  <= par_en & par_bad(sh[DATA_W-1:0], pbit, par_odd);
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mp_rx_buf.sv
module mp_rx_buf
    import mp_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_frame_t         frm,
    input  logic              rd,
    input  logic              atn_set,
    input  logic              fmt9,
    input  logic              irq_en,
    output logic [DATA_W-1:0] data,
    output logic              b9,
    output logic              full,
    output logic              irq,
    output logic              atn,
    output logic              ferr,
    output logic              perr,
    output logic              ovr
);
    logic full_n, ovr_n, atn_n, take;

    always_comb begin
        full_n = full & ~rd;
        ovr_n  = ovr & ~rd;
        take   = 1'b0;
        if (done && !(atn && !frm.b9)) begin
            if (full_n) ovr_n = 1'b1;
            else        take  = 1'b1;
        end
        if (take) full_n = 1'b1;
        atn_n = atn;
        if (take)    atn_n = 1'b0;
        if (atn_set) atn_n = 1'b1;
        if (!fmt9)   atn_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            b9   <= 1'b0;
            ferr <= 1'b0;
            perr <= 1'b0;
            full <= 1'b0;
            ovr  <= 1'b0;
            atn  <= 1'b0;
        end else begin
            full <= full_n;
            ovr  <= ovr_n;
            atn  <= atn_n;
            if (take) begin
                data <= frm.data;
                b9   <= frm.b9;
                ferr <= frm.ferr;
                perr <= frm.perr;
            end
        end
    end

    assign irq = irq_en & full;
endmodule

// File: rtl/mp_rx.sv
module mp_rx
    import mp_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              loop_tx,
    input  logic              loop_en,
    input  logic              tick16,
    input  logic [1:0]        fmt_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              irq_en,
    input  logic              atn_set,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              buf_full,
    output logic              irq,
    output logic              atn,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun
);
    logic       line_raw, line_s;
    logic [1:0] fmt_eff;
    logic       fmt9, par_eff;
    logic       frm_done;
    rx_frame_t  frm;

    assign line_raw = loop_en ? loop_tx : rx_line;
    assign fmt_eff  = loop_en ? 2'd2 : fmt_len;
    assign fmt9     = is_nine(fmt_eff);
    assign par_eff  = par_en & ~fmt9;

    mp_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (line_raw),
        .dout (line_s)
    );

    mp_rx_deser #(.OSR(OSR)) u_deser (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .sin      (line_s),
        .fmt      (fmt_eff),
        .par_en   (par_eff),
        .par_odd  (par_odd),
        .two_stop (two_stop),
        .done     (frm_done),
        .frm      (frm)
    );

    mp_rx_buf u_buf (
        .clk     (clk),
        .rst     (rst),
        .done    (frm_done),
        .frm     (frm),
        .rd      (rd_stb),
        .atn_set (atn_set),
        .fmt9    (fmt9),
        .irq_en  (irq_en),
        .data    (rx_data),
        .b9      (rx_bit9),
        .full    (buf_full),
        .irq     (irq),
        .atn     (atn),
        .ferr    (err_frame),
        .perr    (err_parity),
        .ovr     (err_overrun)
    );
endmodule

// File: rtl/mp_rx_chk.sv
module mp_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq_en,
    input logic       irq,
    input logic       rd_stb,
    input logic       buf_full,
    input logic [7:0] rx_data,
    input logic       atn,
    input logic       frm_done,
    input logic       frm_b9,
    input logic       fmt9
);
    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    // R2
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb && !frm_done |=> !buf_full);

    // R6
    keep_old_chk: assert property (@(posedge clk) disable iff (rst)
        buf_full && !rd_stb |=> $stable(rx_data));

    // R7
    drop_data_chk: assert property (@(posedge clk) disable iff (rst)
        atn && frm_done && !frm_b9 && !rd_stb |=> $stable(buf_full) && $stable(rx_data));

    // R8
    atn_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(atn) |-> ($past(frm_done && frm_b9) || !$past(fmt9)));

    // R9
    atn_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        !fmt9 |=> !atn);
endmodule

bind mp_rx mp_rx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_en   (irq_en),
    .irq      (irq),
    .rd_stb   (rd_stb),
    .buf_full (buf_full),
    .rx_data  (rx_data),
    .atn      (atn),
    .frm_done (frm_done),
    .frm_b9   (frm.b9),
    .fmt9     (fmt9)
);

// File: tb/sim_mp_rx.sv
module sim_mp_rx;
    localparam int CLK_NS = 10;
    localparam int BITC   = 64;   // clocks per bit: tick every 4 clocks, 16 ticks per bit

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_line = 1'b1, loop_tx = 1'b1, loop_en = 1'b0, tick16 = 1'b0;
    logic [1:0] fmt_len = 2'd1;
    logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, irq_en = 1'b0;
    logic atn_set = 1'b0, rd_stb = 1'b0;
    logic [7:0] rx_data;
    logic rx_bit9, buf_full, irq, atn, err_frame, err_parity, err_overrun;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit use_loop = 1'b0;

    mp_rx u0 (
        .clk(clk), .rst(rst), .rx_line(rx_line), .loop_tx(loop_tx), .loop_en(loop_en),
        .tick16(tick16), .fmt_len(fmt_len), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .irq_en(irq_en), .atn_set(atn_set), .rd_stb(rd_stb),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .buf_full(buf_full), .irq(irq), .atn(atn),
        .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
    );

    always #(CLK_NS / 2) clk = ~clk;

    initial begin : tick_gen
        int t;
        t = 0;
        forever begin
            @(negedge clk);
            t = (t + 1) % 4;
            tick16 = (t == 0);
        end
    end

    task automatic chk(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit        h1 = 1'b1, h2 = 1'b1;
    int        ms = 0, mc = 0, mi = 0;
    bit        ms2, mpb, mfe1;
    bit [8:0]  msh;
    bit        pend, pb9, pfe, ppe;
    bit [7:0]  pdat;
    bit [7:0]  m_data;
    bit        m_b9, m_full, m_atn, m_fe, m_pe, m_ovr;

    always @(posedge clk) begin : ref_model
        bit d, f9, pen, nfull, novr, take;
        int nb;
        if (rst) begin
            h1 = 1; h2 = 1; ms = 0; mc = 0; mi = 0; ms2 = 0; mpb = 0; mfe1 = 0; msh = 0;
            pend = 0; m_data = 0; m_b9 = 0; m_full = 0; m_atn = 0; m_fe = 0; m_pe = 0; m_ovr = 0;
        end else begin
            f9  = loop_en || fmt_len[1];
            pen = par_en && !f9;
            nb  = f9 ? 9 : (fmt_len == 2'd0 ? 7 : 8);
            // buffer side, acting on the character finished one cycle earlier
            nfull = m_full && !rd_stb;
            novr  = m_ovr && !rd_stb;
            take  = 0;
            if (pend && !(m_atn && !pb9)) begin
                if (nfull) novr = 1;
                else       take = 1;
            end
            if (take) begin
                m_data = pdat; m_b9 = pb9; m_fe = pfe; m_pe = ppe; nfull = 1; m_atn = 0;
            end
            if (atn_set) m_atn = 1;
            if (!f9)     m_atn = 0;
            m_full = nfull;
            m_ovr  = novr;
            // line after two synchronizer stages
            d  = h2;
            h2 = h1;
            h1 = loop_en ? loop_tx : rx_line;
            pend = 0;
            if (tick16) begin
                case (ms)
                    0: if (!d) begin ms = 1; mc = 0; end
                    1: begin
                        if (mc == 7) begin
                            mc = 0;
                            if (!d) begin ms = 2; mi = 0; msh = 0; end
                            else ms = 0;
                        end else mc++;
                    end
                    2: begin
                        if (mc == 15) begin
                            mc = 0; msh[mi] = d; ms2 = 0;
                            if (mi == nb - 1) ms = pen ? 3 : 4;
                            mi++;
                        end else mc++;
                    end
                    3: begin
                        if (mc == 15) begin mc = 0; mpb = d; ms = 4; end
                        else mc++;
                    end
                    default: begin
                        if (mc == 15) begin
                            mc = 0;
                            if (!ms2) mfe1 = !d;
                            if (!ms2 && two_stop) ms2 = 1;
                            else begin
                                ms   = 0;
                                pend = 1;
                                pdat = msh[7:0];
                                pb9  = f9 && msh[8];
                                pfe  = ms2 ? mfe1 : !d;
                                ppe  = pen && (((^msh[7:0]) ^ mpb) != par_odd);
                            end
                        end else mc++;
                    end
                endcase
            end
        end
    end

    always @(posedge clk) begin : compare
        #2;
        cyc++;
        if (!rst) begin
            chk("R1",  "rx_data",     16'(rx_data),     16'(m_data));
            chk("R3",  "rx_bit9",     16'(rx_bit9),     16'(m_b9));
            chk("R1",  "buf_full",    16'(buf_full),    16'(m_full));
            chk("R11", "irq",         16'(irq),         16'(irq_en & m_full));
            chk("R7",  "atn",         16'(atn),         16'(m_atn));
            chk("R5",  "err_frame",   16'(err_frame),   16'(m_fe));
            chk("R4",  "err_parity",  16'(err_parity),  16'(m_pe));
            chk("R6",  "err_overrun", 16'(err_overrun), 16'(m_ovr));
        end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input bit v, input int n);
        if (use_loop) loop_tx = v;
        else          rx_line = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input int n, input bit par, input bit podd,
                        input bit flip, input int nstop, input bit s1low, input bit s2low);
        bit p;
        logic [8:0] m;
        m = 9'h000;
        drive(1'b0, BITC);
        for (int i = 0; i < n; i++) begin
            drive(d[i], BITC);
            m[i] = d[i];
        end
        if (par) begin
            p = (^m) ^ podd ^ flip;
            drive(p, BITC);
        end
        if (s1low) begin drive(1'b0, 48); drive(1'b1, 16); end
        else drive(1'b1, BITC);
        if (nstop == 2) begin
            if (s2low) begin drive(1'b0, 48); drive(1'b1, 16); end
            else drive(1'b1, BITC);
        end
        drive(1'b1, BITC);
    endtask

    task automatic read_buf();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_atn();
        atn_set = 1'b1;
        @(negedge clk);
        atn_set = 1'b0;
        @(negedge clk);
    endtask

    initial begin : main
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk("R13", "buf_full", 16'(buf_full), 16'h0);
        chk("R13", "rx_data",  16'(rx_data),  16'h0);
        chk("R13", "atn",      16'(atn),      16'h0);
        chk("R13", "errors",   16'({err_frame, err_parity, err_overrun, irq}), 16'h0);

        // R1 8-bit plain
        fmt_len = 2'd1;
        send(9'h0A5, 8, 0, 0, 0, 1, 0, 0);
        chk("R1", "data 8b", 16'(rx_data), 16'h00A5);
        chk("R1", "full",    16'(buf_full), 16'h1);
        chk("R3", "bit9 8b", 16'(rx_bit9), 16'h0);
        read_buf();
        chk("R2", "full after read", 16'(buf_full), 16'h0);

        // R4 7-bit even parity, good then bad
        fmt_len = 2'd0; par_en = 1'b1; par_odd = 1'b0;
        send(9'h055, 7, 1, 0, 0, 1, 0, 0);
        chk("R1", "data 7b", 16'(rx_data), 16'h0055);
        chk("R4", "even ok", 16'(err_parity), 16'h0);
        read_buf();
        send(9'h1FF, 7, 1, 0, 1, 1, 0, 0);
        chk("R1", "7b top bit", 16'(rx_data), 16'h007F);
        chk("R4", "even bad",   16'(err_parity), 16'h1);
        read_buf();

        // R4 8-bit odd parity
        fmt_len = 2'd1; par_odd = 1'b1;
        send(9'h03C, 8, 1, 1, 0, 1, 0, 0);
        chk("R4", "odd ok",  16'(err_parity), 16'h0);
        chk("R1", "data 3C", 16'(rx_data), 16'h003C);
        read_buf();
        send(9'h03C, 8, 1, 1, 1, 1, 0, 0);
        chk("R4", "odd bad", 16'(err_parity), 16'h1);
        read_buf();
        par_en = 1'b0; par_odd = 1'b0;

        // R5 framing
        send(9'h081, 8, 0, 0, 0, 1, 1, 0);
        chk("R5", "stop low", 16'(err_frame), 16'h1);
        chk("R5", "data 81",  16'(rx_data), 16'h0081);
        read_buf();
        two_stop = 1'b1;
        send(9'h042, 8, 0, 0, 0, 2, 0, 1);
        chk("R5", "second stop ignored", 16'(err_frame), 16'h0);
        chk("R5", "data 42",  16'(rx_data), 16'h0042);
        chk("R5", "one char", 16'(buf_full), 16'h1);
        read_buf();
        two_stop = 1'b0;

        // R12 short glitch
        rx_line = 1'b0;
        repeat (12) @(negedge clk);
        rx_line = 1'b1;
        repeat (300) @(negedge clk);
        chk("R12", "glitch no char", 16'(buf_full), 16'h0);

        // R6 overrun
        send(9'h011, 8, 0, 0, 0, 1, 0, 0);
        send(9'h022, 8, 0, 0, 0, 1, 0, 0);
        chk("R6", "keeps old", 16'(rx_data), 16'h0011);
        chk("R6", "overrun",   16'(err_overrun), 16'h1);
        read_buf();
        chk("R2", "overrun cleared", 16'(err_overrun), 16'h0);

        // R11 interrupt
        irq_en = 1'b1;
        send(9'h066, 8, 0, 0, 0, 1, 0, 0);
        chk("R11", "irq on", 16'(irq), 16'h1);
        irq_en = 1'b0;
        #1;
        chk("R11", "irq masked", 16'(irq), 16'h0);
        irq_en = 1'b1;
        @(negedge clk);
        read_buf();
        chk("R11", "irq after read", 16'(irq), 16'h0);
        irq_en = 1'b0;

        // R3 nine-bit, par_en ignored
        fmt_len = 2'd2; par_en = 1'b1;
        send(9'h1C3, 9, 0, 0, 0, 1, 0, 0);
        chk("R3", "bit9",    16'(rx_bit9), 16'h1);
        chk("R3", "data C3", 16'(rx_data), 16'h00C3);
        chk("R3", "no par",  16'(err_parity), 16'h0);
        read_buf();
        par_en = 1'b0;

        // R7 / R8 attention
        pulse_atn();
        chk("R7", "atn raised", 16'(atn), 16'h1);
        send(9'h012, 9, 0, 0, 0, 1, 0, 0);
        chk("R7", "data dropped", 16'(buf_full), 16'h0);
        chk("R7", "atn held",     16'(atn), 16'h1);
        send(9'h134, 9, 0, 0, 0, 1, 0, 0);
        chk("R8", "addr taken", 16'(buf_full), 16'h1);
        chk("R8", "addr data",  16'(rx_data), 16'h0034);
        chk("R8", "addr bit9",  16'(rx_bit9), 16'h1);
        chk("R8", "atn fell",   16'(atn), 16'h0);
        read_buf();
        send(9'h056, 9, 0, 0, 0, 1, 0, 0);
        chk("R8", "later data", 16'(rx_data), 16'h0056);
        chk("R8", "later full", 16'(buf_full), 16'h1);
        read_buf();

        // R9 attention outside nine-bit
        fmt_len = 2'd1;
        @(negedge clk);
        pulse_atn();
        chk("R9", "atn ignored 8b", 16'(atn), 16'h0);
        fmt_len = 2'd2;
        pulse_atn();
        fmt_len = 2'd1;
        repeat (2) @(negedge clk);
        chk("R9", "atn cleared by fmt", 16'(atn), 16'h0);

        // R10 loopback, conflicting format, rx_line held low
        loop_en = 1'b1; use_loop = 1'b1; rx_line = 1'b0; par_en = 1'b1;
        send(9'h1A7, 9, 0, 0, 0, 1, 0, 0);
        chk("R10", "loop data", 16'(rx_data), 16'h00A7);
        chk("R10", "loop bit9", 16'(rx_bit9), 16'h1);
        chk("R10", "loop no par", 16'(err_parity), 16'h0);
        read_buf();
        rx_line = 1'b1; loop_en = 1'b0; use_loop = 1'b0; par_en = 1'b0;
        repeat (100) @(negedge clk);
        chk("R10", "no stray char", 16'(buf_full), 16'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule